// File: doc/BRIEF.md
# Strobe-Driven FIFO Queue with Read Rewind

This block is a 9-bit first-in/first-out queue that a writer and a reader drive with separate active-low strobes. A word is taken in when the write strobe returns high. The oldest stored word is moved to the output register when the read strobe goes low.

Three active-low flags report the queue state: full, empty and more-than-half occupied. A rewind input returns the read position to the first storage location, so the words already stored can be read out a second time. The write position does not move on a rewind.

Both strobes and the rewind input are asynchronous to the block. Each one passes through a two-stage synchronizer on the system clock, and its edges are found by comparing the current sample with the previous one. A strobe edge that the queue cannot accept is dropped and raises a one-cycle error pulse.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released, the queue is empty. `full_n`=1, `empty_n`=0, `half_n`=1, `dout`=0, and `ovf_err` and `unf_err` are 0.
- R2: A low-to-high transition of `wr_n` stores `din` at the write position, provided fewer than DEPTH words are held. Words leave in the order they were stored.
- R3: A high-to-low transition of `rd_n` loads the oldest stored word into `dout`, provided at least one word is held. At all other times `dout` holds its value.
- R4: With DEPTH words held, `full_n` is 0. A write edge in that state stores nothing, leaves the stored data intact, and drives `ovf_err` high for exactly one clock.
- R5: After a read from a full queue, `full_n` returns to 1.
- R6: With no words held, `empty_n` is 0. A read edge in that state leaves `dout` unchanged and drives `unf_err` high for exactly one clock.
- R7: After a write into an empty queue, `empty_n` returns to 1.
- R8: While `solo`=1, `half_n` is 0 exactly when more than DEPTH/2 words are held. While `solo`=0, `half_n` is 1.
- R9: A high-to-low transition of `ret_n` sets the read position to the first location. The occupancy becomes the write position, which is the count of words written since reset, modulo DEPTH. Later reads then replay the data from the first word.
- R10: The effect of a strobe edge on `dout` and on the flags appears at most three clock rising edges after the edge on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Write strobe; a store happens on its rising edge |
| rd_n | input | 1 | Read strobe; a fetch happens on its falling edge |
| ret_n | input | 1 | Rewind; acts on its falling edge |
| solo | input | 1 | 1 = single-device mode; enables `half_n` |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Last word read |
| full_n | output | 1 | Low when the queue is full |
| empty_n | output | 1 | Low when the queue is empty |
| half_n | output | 1 | Low when more than half full (single mode only) |
| ovf_err | output | 1 | One-cycle pulse for a write edge that was refused |
| unf_err | output | 1 | One-cycle pulse for a read edge that was refused |

## Verification
If the occupancy counter is wrong, the flags show it within three clocks of the strobe edge that caused it. `empty_n` or `full_n` then changes a step too early or too late, and a fill or a drain of DEPTH words exposes the off-by-one. If a pointer is wrong, `dout` is wrong on the very next read, because each stored word carries a distinct value. If a refused write or read moves a pointer, the fault shows as a shifted sequence when the queue is later drained or replayed after a rewind.

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             ret_n,
  input  logic             solo,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full_n,
  output logic             empty_n,
  output logic             half_n,
  output logic             ovf_err,
  output logic             unf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [2:0] wr_q, rd_q, rt_q;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 3'b111;
      rd_q <= 3'b111;
      rt_q <= 3'b111;
    end else begin
      wr_q <= {wr_q[1:0], wr_n};
      rd_q <= {rd_q[1:0], rd_n};
      rt_q <= {rt_q[1:0], ret_n};
    end
  end

  wire wr_rise = wr_q[1] & ~wr_q[2];
  wire rd_fall = ~rd_q[1] & rd_q[2];
  wire rt_fall = ~rt_q[1] & rt_q[2];
  wire is_full  = (count == FULL_CNT);
  wire is_empty = (count == '0);
  wire wr_ok = wr_rise & ~is_full;
  wire rd_ok = rd_fall & ~is_empty & ~rt_fall;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      dout    <= '0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      ovf_err <= wr_rise & is_full;
      unf_err <= rd_fall & is_empty & ~rt_fall;
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rt_fall) begin
        rptr  <= '0;
        count <= {1'b0, wptr} + CW'(wr_ok);
      end else begin
        if (rd_ok) begin
          rptr <= rptr + 1'b1;
          dout <= mem[rptr];
        end
        count <= count + CW'(wr_ok) - CW'(rd_ok);
      end
    end
  end

  assign full_n  = ~is_full;
  assign empty_n = ~is_empty;
  assign half_n  = ~(solo & (count > HALF_CNT));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R4
  AST_FULL_WPTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_rise) |=> $stable(wptr)); // R4
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> !ovf_err); // R4
  AST_EMPTY_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_fall) |=> $stable(dout)); // R6
  AST_UNF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> !unf_err); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n)); // R5
  AST_RET_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    rt_fall |=> (rptr == '0)); // R9
endmodule

// File: tb/tb_strobe_fifo.sv
`timescale 1ns/1ps
module tb_strobe_fifo;
  localparam int DEPTH = 256;
  localparam int WIDTH = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, ret_n = 1'b1, solo = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic full_n, empty_n, half_n, ovf_err, unf_err;

  int checks = 0, fails = 0, ovf_cnt = 0, unf_cnt = 0;
  bit done = 1'b0;

  strobe_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .ret_n(ret_n),
    .solo(solo), .din(din), .dout(dout), .full_n(full_n),
    .empty_n(empty_n), .half_n(half_n), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (ovf_err) ovf_cnt++;
    if (unf_err) unf_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [WIDTH-1:0] d);
    @(negedge clk); din = d; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_ret();
    @(negedge clk); ret_n = 1'b0;
    repeat (4) @(negedge clk);
    ret_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // {op[1:0], data[8:0], exp_dout[8:0], exp_empty_n, exp_full_n}; op 0=write 1=read 2=rewind
  localparam logic [21:0] VEC [9] = '{
    {2'd0, 9'h1A5, 9'h000, 1'b1, 1'b1},
    {2'd0, 9'h03C, 9'h000, 1'b1, 1'b1},
    {2'd1, 9'h000, 9'h1A5, 1'b1, 1'b1},
    {2'd0, 9'h0FF, 9'h1A5, 1'b1, 1'b1},
    {2'd1, 9'h000, 9'h03C, 1'b1, 1'b1},
    {2'd1, 9'h000, 9'h0FF, 1'b0, 1'b1},
    {2'd1, 9'h000, 9'h0FF, 1'b0, 1'b1},
    {2'd2, 9'h000, 9'h0FF, 1'b1, 1'b1},
    {2'd1, 9'h000, 9'h1A5, 1'b1, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 full_n", full_n, 1);
    check("R1 empty_n", empty_n, 0);
    check("R1 half_n", half_n, 1);
    check("R1 dout", dout, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 errors", {ovf_err, unf_err}, 0);

    for (int i = 0; i < 9; i++) begin
      case (VEC[i][21:20])
        2'd0: do_write(VEC[i][19:11]);
        2'd1: do_read();
        default: do_ret();
      endcase
      check("R2 R3 R9 vector dout", dout, VEC[i][10:2]);
      check("R6 R7 vector empty_n", empty_n, VEC[i][1]);
      check("R4 vector full_n", full_n, VEC[i][0]);
    end
    check("R6 underflow pulses", unf_cnt, 1);

    // R10: effect visible within three clock edges of the strobe edge
    @(negedge clk); rd_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R10 read latency", dout, 9'h03C);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset empty_n", empty_n, 0);
    check("R1 reset dout", dout, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < DEPTH; i++) begin
      do_write(WIDTH'(i) ^ 9'h155);
      if (i == DEPTH / 2 - 1) check("R8 half_n at exactly half", half_n, 1);
      if (i == DEPTH / 2) begin
        check("R8 half_n above half", half_n, 0);
        solo = 1'b0; @(negedge clk);
        check("R8 half_n off outside single mode", half_n, 1);
        solo = 1'b1; @(negedge clk);
      end
      if (i == DEPTH - 2) check("R4 not yet full", full_n, 1);
    end
    check("R4 full_n at DEPTH", full_n, 0);
    do_write(9'h0AA);
    check("R4 overflow pulses", ovf_cnt, 1);
    check("R4 still full", full_n, 0);

    do_read();
    check("R5 full_n after read", full_n, 1);
    check("R2 first word after overflow", dout, 9'h155);
    for (int i = 1; i < DEPTH; i++) begin
      do_read();
      if (dout != (WIDTH'(i) ^ 9'h155))
        check("R2 drain order", dout, WIDTH'(i) ^ 9'h155);
      else checks++;
    end
    check("R6 empty after drain", empty_n, 0);
    do_read();
    check("R6 underflow dout held", dout, 9'h0AA ^ 9'h155 ^ 9'h155 ^ 9'h0AA ^ ((WIDTH'(DEPTH - 1)) ^ 9'h155));
    check("R6 second underflow", unf_cnt, 2);

    do_write(9'h011);
    check("R7 empty_n after write", empty_n, 1);
    do_ret();
    check("R9 occupancy from write position", empty_n, 1);
    do_read();
    check("R9 replay first location", dout, 9'h011);
    check("R9 empty after replay", empty_n, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule